// File: doc/BRIEF.md
# Cartridge Mapper Port Register File

This block models the I/O port space of a handheld cartridge banking mapper. A host drives an 8-bit port number with read and write strobes. Thirty-two byte-wide registers live at ports 0xC0 to 0xDF, each coming out of reset with a fixed image. Ports 0xE0 to 0xFF read as zero and ignore writes. Port 0xCA is not storage: it reports the state of an external real-time-clock command engine.

The block also sits on the ROM read path. When bit 0 of the control register at port 0xCE is set, ROM reads in the window 0x20000 to 0xFFFFF return 0xFF and do not pass flash data through. The block also builds the flash byte address from a 4-bit slot number supplied from outside and a 23-bit offset inside one 8 MB slot.

The block has no sequencing of its own, so it has no state machine. Its only state is the register storage. Writes land on the clock edge. The port read data and the ROM data path are combinational.

Top module: `cart_port_regs`

## Requirements
- R1: After reset, ports 0xC0..0xDF read 3F FF FF FF 00 00 00 00 00 00 84 00 00 00 00 3F FF 03 FF 03 FF 03 and then 00 for the last ten ports, in ascending port order. Port 0xCA reads 84 here because the busy input is low.
- R2: A write to any port in 0xC0..0xDF other than 0xCA stores all eight data bits. A read of that port in the cycle after the write edge returns the written byte.
- R3: Port 0xCF is a separate register from port 0xC0. A write to either one leaves the other unchanged, and bit 0 of 0xCF has no effect on the ROM data path.
- R4: Writes to ports 0xE0..0xFF have no effect, and reads of those ports return 0x00.
- R5: A read of port 0xCA returns 0x94 while rtc_busy is 1 and 0x84 while it is 0. Writes to 0xCA do not change this.
- R6: While bit 0 of port 0xCE is 1, rom_rdata is 0xFF for any rom_addr from 0x20000 to 0xFFFFF. While that bit is 0, rom_rdata equals flash_rdata.
- R7: For rom_addr below 0x20000, rom_rdata equals flash_rdata whatever the value of port 0xCE.
- R8: flash_addr equals {slot, rom_offset}, with the slot in bits 26:23 and the offset in bits 22:0.
- R9: port_rdata is 0x00 whenever port_rd is 0 or the port number is below 0xC0.
- R10: A register write takes effect at the rising clock edge where port_wr is 1. Reads and the ROM gating follow their inputs in the same cycle with no register delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| port_addr | input | 8 | I/O port number |
| port_wr | input | 1 | Write strobe, sampled at the rising edge |
| port_rd | input | 1 | Read strobe |
| port_wdata | input | 8 | Write data |
| port_rdata | output | 8 | Read data, combinational |
| rtc_busy | input | 1 | RTC command engine is processing a command |
| slot | input | 4 | Selected 64 Mbit flash slot |
| rom_offset | input | 23 | Byte offset inside the selected slot |
| flash_addr | output | 27 | Flash byte address |
| rom_addr | input | 20 | CPU memory address of the current ROM read |
| flash_rdata | input | 8 | Data returned by the flash |
| rom_rdata | output | 8 | Data presented to the cartridge bus |

## Verification
port_rdata, rom_rdata and flash_addr are due in the same cycle as the inputs that select them. A stored byte, and any change to the ROM gating that follows from a write to port 0xCE, is due in the cycle after the rising edge where the write is accepted. The bench drives inputs just after the falling edge and compares every output a short delay later, which is still before the next rising edge. The reference model applies a write only at that rising edge, so a result that arrives one cycle early or one cycle late shows up as a mismatch.

// File: rtl/cpr_pkg.sv
package cpr_pkg;
    localparam int          NREG       = 32;
    localparam int          IDX_W      = $clog2(NREG);
    localparam logic [7:0]  PORT_BASE  = 8'hC0;
    localparam int          STATUS_IDX = 10;
    localparam int          CTRL_IDX   = 14;
    localparam logic [7:0]  STAT_BUSY  = 8'h94;
    localparam logic [7:0]  STAT_IDLE  = 8'h84;

    typedef enum logic [1:0] {
        SPACE_OUTSIDE,
        SPACE_REG,
        SPACE_STATUS,
        SPACE_ZERO
    } space_e;

    function automatic logic [7:0] rst_val(int i);
        case (i)
            0, 15:          return 8'h3F;
            1, 2, 3:        return 8'hFF;
            16, 18, 20:     return 8'hFF;
            17, 19, 21:     return 8'h03;
            STATUS_IDX:     return STAT_IDLE;
            default:        return 8'h00;
        endcase
    endfunction
endpackage

// File: rtl/cpr_regbank.sv
module cpr_regbank
    import cpr_pkg::*;
(
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_en,
    input  logic [IDX_W-1:0]            wr_idx,
    input  logic [7:0]                  wr_data,
    output logic [NREG-1:0][7:0]        regs_q
);
    for (genvar i = 0; i < NREG; i++) begin : g_reg
        if (i == STATUS_IDX) begin : g_hole
            assign regs_q[i] = rst_val(i);
        end else begin : g_store
            always_ff @(posedge clk) begin
                if (!rst_n)
                    regs_q[i] <= rst_val(i);
                else if (wr_en && wr_idx == IDX_W'(i))
                    regs_q[i] <= wr_data;
            end
        end
    end

    // R2 / R10: an accepted write is visible on the next cycle
    a_r2_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && wr_idx != IDX_W'(STATUS_IDX) |=> regs_q[$past(wr_idx)] == $past(wr_data));

    // R10: storage holds without a write
    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(regs_q));
endmodule

// File: rtl/cpr_rom_gate.sv
module cpr_rom_gate #(
    parameter int               AW     = 20,
    parameter int               DW     = 8,
    parameter logic [AW-1:0]    GATE_LO = 20'h20000
) (
    input  logic            disconnect,
    input  logic [AW-1:0]   addr,
    input  logic [DW-1:0]   flash_data,
    output logic [DW-1:0]   bus_data
);
    logic in_window;

    always_comb begin
        in_window = (addr >= GATE_LO);
        bus_data  = (disconnect && in_window) ? {DW{1'b1}} : flash_data;
    end
endmodule

// File: rtl/cart_port_regs.sv
module cart_port_regs
    import cpr_pkg::*;
#(
    parameter int SLOT_W = 4,
    parameter int OFS_W  = 23,
    parameter int ROM_AW = 20,
    localparam int FA_W  = SLOT_W + OFS_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [7:0]          port_addr,
    input  logic                port_wr,
    input  logic                port_rd,
    input  logic [7:0]          port_wdata,
    output logic [7:0]          port_rdata,
    input  logic                rtc_busy,
    input  logic [SLOT_W-1:0]   slot,
    input  logic [OFS_W-1:0]    rom_offset,
    output logic [FA_W-1:0]     flash_addr,
    input  logic [ROM_AW-1:0]   rom_addr,
    input  logic [7:0]          flash_rdata,
    output logic [7:0]          rom_rdata
);
    localparam logic [7:0] ZERO_BASE = PORT_BASE + 8'(NREG);

    space_e                 space;
    logic [IDX_W-1:0]       idx;
    logic [NREG-1:0][7:0]   regs_q;
    logic                   reg_wr;

    always_comb begin
        idx = port_addr[IDX_W-1:0];
        if (port_addr < PORT_BASE)
            space = SPACE_OUTSIDE;
        else if (port_addr >= ZERO_BASE)
            space = SPACE_ZERO;
        else if (idx == IDX_W'(STATUS_IDX))
            space = SPACE_STATUS;
        else
            space = SPACE_REG;
        reg_wr = port_wr && (space == SPACE_REG);
    end

    cpr_regbank u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (reg_wr),
        .wr_idx  (idx),
        .wr_data (port_wdata),
        .regs_q  (regs_q)
    );

    always_comb begin
        port_rdata = 8'h00;
        if (port_rd) begin
            unique case (space)
                SPACE_REG:     port_rdata = regs_q[idx];
                SPACE_STATUS:  port_rdata = rtc_busy ? STAT_BUSY : STAT_IDLE;
                SPACE_ZERO,
                SPACE_OUTSIDE: port_rdata = 8'h00;
            endcase
        end
    end

    cpr_rom_gate #(
        .AW      (ROM_AW),
        .DW      (8),
        .GATE_LO (ROM_AW'(20'h20000))
    ) u_gate (
        .disconnect (regs_q[CTRL_IDX][0]),
        .addr       (rom_addr),
        .flash_data (flash_rdata),
        .bus_data   (rom_rdata)
    );

    assign flash_addr = {slot, rom_offset};

    // R4: upper ports always read zero
    a_r4_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        port_rd && port_addr >= ZERO_BASE |-> port_rdata == 8'h00);

    // R6: setting the disconnect bit forces 0xFF in the window on the next cycle
    a_r6_disconnect: assert property (@(posedge clk) disable iff (!rst_n)
        port_wr && port_addr == PORT_BASE + 8'(CTRL_IDX) && port_wdata[0]
        |=> (rom_addr < ROM_AW'(20'h20000)) || rom_rdata == 8'hFF);

    // R5: status port reflects busy input
    a_r5_status: assert property (@(posedge clk) disable iff (!rst_n)
        port_rd && port_addr == PORT_BASE + 8'(STATUS_IDX) && !rtc_busy |-> port_rdata == STAT_IDLE);
endmodule

// File: tb/sim_cart_port_regs.sv
module sim_cart_port_regs;
    localparam int CLK_PERIOD = 10;

    logic        clk = 0;
    logic        rst_n = 0;
    logic [7:0]  port_addr = 0;
    logic        port_wr = 0;
    logic        port_rd = 0;
    logic [7:0]  port_wdata = 0;
    logic [7:0]  port_rdata;
    logic        rtc_busy = 0;
    logic [3:0]  slot = 0;
    logic [22:0] rom_offset = 0;
    logic [26:0] flash_addr;
    logic [19:0] rom_addr = 0;
    logic [7:0]  flash_rdata = 0;
    logic [7:0]  rom_rdata;

    int errors = 0;
    int checks = 0;
    logic [7:0] model [32];

    always #(CLK_PERIOD/2) clk = ~clk;

    cart_port_regs u0 (.*);

    function automatic logic [7:0] exp_port();
        if (!port_rd || port_addr < 8'hC0 || port_addr >= 8'hE0) return 8'h00;
        if (port_addr == 8'hCA) return rtc_busy ? 8'h94 : 8'h84;
        return model[port_addr - 8'hC0];
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    // drive at negedge, compare combinational outputs, then let the edge commit
    task automatic step(string req, logic wr, logic rd, logic [7:0] a, logic [7:0] d);
        @(negedge clk);
        port_wr = wr; port_rd = rd; port_addr = a; port_wdata = d;
        #2;
        check(req, port_rdata, exp_port());
        check("R8", flash_addr, {slot, rom_offset});
        if (model[14][0] && rom_addr >= 20'h20000) check("R6", rom_rdata, 8'hFF);
        else if (rom_addr < 20'h20000) check("R7", rom_rdata, flash_rdata);
        else check("R6", rom_rdata, flash_rdata);
        @(posedge clk);
        if (wr && a >= 8'hC0 && a < 8'hE0 && a != 8'hCA) model[a - 8'hC0] = d;
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        errors++;
        $display("FAIL watchdog actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        model = '{8'h3F,8'hFF,8'hFF,8'hFF,8'h00,8'h00,8'h00,8'h00,8'h00,8'h00,8'h84,
                  8'h00,8'h00,8'h00,8'h00,8'h3F,8'hFF,8'h03,8'hFF,8'h03,8'hFF,8'h03,
                  8'h00,8'h00,8'h00,8'h00,8'h00,8'h00,8'h00,8'h00,8'h00,8'h00};
        repeat (3) @(posedge clk);
        rst_n = 1;
        // R1 reset image
        for (int i = 0; i < 32; i++) step("R1", 0, 1, 8'(8'hC0 + i), 0);
        // R9 read strobe low / below range
        step("R9", 0, 0, 8'hC1, 0);
        step("R9", 0, 1, 8'h7F, 0);
        // R2 / R10 write then read every storing port
        for (int i = 0; i < 32; i++) begin
            step("R2", 1, 0, 8'(8'hC0 + i), 8'(8'hA5 ^ (i * 7)));
            step("R10", 0, 1, 8'(8'hC0 + i), 0);
        end
        // R3 independence of C0 and CF; CF bit0 no disconnect
        step("R3", 1, 0, 8'hCE, 8'h00);
        step("R3", 1, 0, 8'hC0, 8'h11);
        step("R3", 0, 1, 8'hCF, 0);
        step("R3", 1, 0, 8'hCF, 8'h01);
        step("R3", 0, 1, 8'hC0, 0);
        rom_addr = 20'h30000; flash_rdata = 8'h5A;
        step("R3", 0, 1, 8'hCF, 0);
        check("R3", rom_rdata, 8'h5A);
        // R4 upper half
        step("R4", 1, 0, 8'hE3, 8'h77);
        step("R4", 0, 1, 8'hE3, 0);
        step("R4", 1, 0, 8'hFF, 8'h12);
        step("R4", 0, 1, 8'hFF, 0);
        // R5 status port
        step("R5", 1, 0, 8'hCA, 8'h00);
        rtc_busy = 1; step("R5", 0, 1, 8'hCA, 0);
        rtc_busy = 0; step("R5", 0, 1, 8'hCA, 0);
        // R6 / R7 disconnect
        step("R6", 1, 0, 8'hCE, 8'h01);
        rom_addr = 20'h20000; flash_rdata = 8'h3C; step("R6", 0, 0, 8'h00, 0);
        rom_addr = 20'hFFFFF; step("R6", 0, 0, 8'h00, 0);
        rom_addr = 20'h1FFFF; step("R7", 0, 0, 8'h00, 0);
        rom_addr = 20'h00000; step("R7", 0, 0, 8'h00, 0);
        step("R6", 1, 0, 8'hCE, 8'hFE);
        rom_addr = 20'h80000; step("R6", 0, 0, 8'h00, 0);
        // R8 slot mapping
        slot = 4'hF; rom_offset = 23'h7FFFFF; step("R8", 0, 0, 8'h00, 0);
        slot = 4'h9; rom_offset = 23'h012345; step("R8", 0, 0, 8'h00, 0);
        // mixed random traffic against the model
        for (int n = 0; n < 600; n++) begin
            rtc_busy = 1'($urandom);
            slot = 4'($urandom); rom_offset = 23'($urandom);
            rom_addr = 20'($urandom); flash_rdata = 8'($urandom);
            step("R2", 1'($urandom), 1'($urandom), 8'($urandom_range(8'hB8, 8'hFF)), 8'($urandom));
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule